// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command and address pins from reset until the memory can accept normal traffic. After reset it holds the bus idle for a programmable number of clock cycles. It then issues a precharge to every bank and a configurable number of auto-refresh commands. Last, it issues a load-mode-register command that places the configuration word on the address lines. Each command is followed by an idle gap whose length is a parameter. When the final gap has elapsed, the block raises a ready flag and keeps the bus idle.

The mode word is assembled from four small inputs: a burst-length code, a burst-type bit, a CAS-latency field and a write-mode bit. The burst-length input is only two bits wide, so only the lengths 1, 2, 4 and 8 can be programmed. The mode inputs are decoded only in the cycle in which the load-mode command is on the bus. A command is the level of {cs_n, ras_n, cas_n, we_n} during one clock cycle.

Cycle numbering: n counts the rising clock edges seen with rst_n high since reset was last released, and n = 0 is the cycle just after release. With P = T_POWERUP, the precharge is at n = P, the refreshes are at P + T_RP + k·T_RFC, the load-mode command is at L = P + T_RP + N_REFRESH·T_RFC, and the ready flag rises at L + T_MRD.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_n is low, and for the first T_POWERUP cycles after release (n < T_POWERUP), the command is NOP (0111), addr and ba are zero, and init_done is 0.
- R2: In each complete sequence exactly one precharge, exactly N_REFRESH auto-refreshes and exactly one load-mode command appear, in that order. Every other cycle carries NOP.
- R3: The precharge (command 0010) is driven for one cycle at n = T_POWERUP, with addr = 13'h0400 (only bit 10 set) and ba = 0.
- R4: Each auto-refresh (command 0001) lasts one cycle. The first comes T_RP cycles after the precharge and each later one comes T_RFC cycles after the one before it. addr and ba are zero.
- R5: The load-mode command (command 0000) comes T_RFC cycles after the last refresh, with ba = 0. Its addr is: bits [2:0] the burst-length field, bit 3 mode_bt, bits [6:4] mode_cas, bit 9 mode_wr_single. The values are taken from the inputs in that same cycle.
- R6: Burst-length code 0, 1, 2, 3 places 000, 001, 010, 011 on addr[2:0] (lengths 1, 2, 4, 8). During load-mode, addr bits 2, 7, 8, 10, 11 and 12 are always zero.
- R7: init_done rises exactly T_MRD cycles after the load-mode command. It then stays high with NOP on the bus until rst_n is asserted.
- R8: Asserting rst_n at any point in the sequence returns the outputs to the R1 state. The next release restarts the whole sequence from n = 0.
- R9: A gap parameter of 1 places the next command in the very next cycle, with no NOP between the two commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_bl_code | input | 2 | Burst-length code: 0=1, 1=2, 2=4, 3=8 |
| mode_bt | input | 1 | Burst type, placed on addr[3] |
| mode_cas | input | 3 | CAS latency, placed on addr[6:4] |
| mode_wr_single | input | 1 | Write burst mode, placed on addr[9] |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Address bus |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
Two decisions can fall on the same clock edge: a gap expires, and the refresh counter decides whether the next command is another refresh or the load-mode command. With unit gaps, command issue and the choice of the next command even coincide in consecutive cycles. The bench runs a second instance with every gap set to 1 and a single refresh, next to the default instance, so that both situations arise. A reset is also dropped into the middle of a sequence. A behavioural timeline model predicts the command, address, bank and ready flag for every cycle, and the bench compares both instances against it on every clock while the mode inputs change every cycle.

// File: rtl/sdram_init_pkg.sv
// Package: shared encodings for the SDRAM initialization sequencer.
// Assumes a 13-bit address bus and a 2-bit bank bus.
package sdram_init_pkg;

    localparam int ADDR_W    = 13;
    localparam int BA_W      = 2;
    localparam int ALLBK_BIT = 10;

    // Command levels on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdram_cmd_e;

    // Phases of the initialization script
    typedef enum logic [2:0] {
        PH_PWR  = 3'd0,
        PH_PRE  = 3'd1,
        PH_PGAP = 3'd2,
        PH_REF  = 3'd3,
        PH_RGAP = 3'd4,
        PH_LMR  = 3'd5,
        PH_MGAP = 3'd6,
        PH_DONE = 3'd7
    } init_phase_e;

    // Builds the mode-register word from its fields; reserved bits are zero
    function automatic logic [ADDR_W-1:0] build_mode_word(
        input logic [1:0] bl_code,
        input logic       bt,
        input logic [2:0] cas,
        input logic       wr_single
    );
        logic [ADDR_W-1:0] w;
        w       = '0;
        w[2:0]  = {1'b0, bl_code};
        w[3]    = bt;
        w[6:4]  = cas;
        w[9]    = wr_single;
        return w;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
// Module: down-counter that times the idle gaps of the initialization script.
// Starts from RST_VAL on reset; a load overrides counting; zero is flagged.
// Assumes RST_VAL fits in CNT_W bits.
module sdram_init_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Gap is over when the count reaches zero
    always_comb begin
        expired = (cnt_q == '0);
    end

endmodule

// File: rtl/sdram_init_ctrl.sv
// Module: phase controller that walks the fixed initialization script.
// Every command phase lasts one cycle. A following gap phase holds for
// (gap - 1) cycles, and is skipped when the gap parameter is 1.
// Assumes all gap parameters are >= 1 and N_REFRESH >= 1.
module sdram_init_ctrl
    import sdram_init_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 8,
    parameter int T_MRD     = 2,
    parameter int N_REFRESH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output init_phase_e      phase
);

    localparam int RC_W = $clog2(N_REFRESH + 1);
    localparam bit RP_B2B  = (T_RP  < 2);
    localparam bit RFC_B2B = (T_RFC < 2);
    localparam bit MRD_B2B = (T_MRD < 2);
    localparam logic [CNT_W-1:0] GAP_RP  = CNT_W'(RP_B2B  ? 0 : T_RP  - 2);
    localparam logic [CNT_W-1:0] GAP_RFC = CNT_W'(RFC_B2B ? 0 : T_RFC - 2);
    localparam logic [CNT_W-1:0] GAP_MRD = CNT_W'(MRD_B2B ? 0 : T_MRD - 2);
    localparam logic [RC_W-1:0]  REF_ALL  = RC_W'(N_REFRESH);
    localparam logic [RC_W-1:0]  REF_LAST = RC_W'(N_REFRESH - 1);

    init_phase_e      phase_q, phase_d;
    logic [RC_W-1:0]  refs_q, refs_d;

    // Hold phase and refresh tally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PWR;
            refs_q  <= '0;
        end else begin
            phase_q <= phase_d;
            refs_q  <= refs_d;
        end
    end

    // Pick the next phase of the script and any gap to load
    always_comb begin
        phase_d  = phase_q;
        refs_d   = refs_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_PWR: begin
                if (tmr_expired) phase_d = PH_PRE;
            end
            PH_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = GAP_RP;
                phase_d  = RP_B2B ? PH_REF : PH_PGAP;
            end
            PH_PGAP: begin
                if (tmr_expired) phase_d = PH_REF;
            end
            PH_REF: begin
                refs_d   = refs_q + 1'b1;
                tmr_load = 1'b1;
                tmr_val  = GAP_RFC;
                if (!RFC_B2B) begin
                    phase_d = PH_RGAP;
                end else if (refs_q == REF_LAST) begin
                    phase_d = PH_LMR;
                end else begin
                    phase_d = PH_REF;
                end
            end
            PH_RGAP: begin
                if (tmr_expired) phase_d = (refs_q == REF_ALL) ? PH_LMR : PH_REF;
            end
            PH_LMR: begin
                tmr_load = 1'b1;
                tmr_val  = GAP_MRD;
                phase_d  = MRD_B2B ? PH_DONE : PH_MGAP;
            end
            PH_MGAP: begin
                if (tmr_expired) phase_d = PH_DONE;
            end
            default: begin
                phase_d = PH_DONE;
            end
        endcase
    end

    // Expose current phase to the pin decoder
    always_comb begin
        phase = phase_q;
    end

endmodule

// File: rtl/sdram_cmd_encode.sv
// Module: maps the current script phase onto SDRAM command, bank and
// address levels. Idle and gap phases drive NOP with a zero address.
// Assumes the phase input comes straight from a register.
module sdram_cmd_encode
    import sdram_init_pkg::*;
(
    input  init_phase_e        phase,
    input  logic [1:0]         mode_bl_code,
    input  logic               mode_bt,
    input  logic [2:0]         mode_cas,
    input  logic               mode_wr_single,
    output logic [3:0]         cmd,
    output logic [BA_W-1:0]    ba,
    output logic [ADDR_W-1:0]  addr,
    output logic               ready
);

    // Decode pins from the phase
    always_comb begin
        cmd   = CMD_NOP;
        ba    = '0;
        addr  = '0;
        ready = 1'b0;
        case (phase)
            PH_PRE: begin
                cmd             = CMD_PRE;
                addr[ALLBK_BIT] = 1'b1;
            end
            PH_REF: begin
                cmd = CMD_REF;
            end
            PH_LMR: begin
                cmd  = CMD_LMR;
                addr = build_mode_word(mode_bl_code, mode_bt, mode_cas, mode_wr_single);
            end
            PH_DONE: begin
                ready = 1'b1;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
// Module: top of the SDRAM power-up initialization sequencer.
// It waits out the power-up time, then drives a precharge to all banks,
// N_REFRESH refreshes and a load-mode command, and then raises init_done.
// Assumes every T_* parameter is >= 1 and N_REFRESH >= 1.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int T_POWERUP = 12500,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 8,
    parameter int T_MRD     = 2,
    parameter int N_REFRESH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_bl_code,
    input  logic        mode_bt,
    input  logic [2:0]  mode_cas,
    input  logic        mode_wr_single,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [12:0] addr,
    output logic        init_done
);

    localparam int T_MAX_A = (T_POWERUP > T_RP)  ? T_POWERUP : T_RP;
    localparam int T_MAX_B = (T_RFC     > T_MRD) ? T_RFC     : T_MRD;
    localparam int T_MAX   = (T_MAX_A   > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    logic             tmr_expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    init_phase_e      phase;
    logic [3:0]       cmd;

    sdram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (T_POWERUP - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_init_ctrl #(
        .CNT_W     (CNT_W),
        .T_RP      (T_RP),
        .T_RFC     (T_RFC),
        .T_MRD     (T_MRD),
        .N_REFRESH (N_REFRESH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .phase       (phase)
    );

    sdram_cmd_encode u_enc (
        .phase          (phase),
        .mode_bl_code   (mode_bl_code),
        .mode_bt        (mode_bt),
        .mode_cas       (mode_cas),
        .mode_wr_single (mode_wr_single),
        .cmd            (cmd),
        .ba             (ba),
        .addr           (addr),
        .ready          (init_done)
    );

    // Split the command level onto the four strobes
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = cmd;
    end

endmodule

// File: rtl/sdram_init_chk.sv
// Module: protocol checker for the initialization sequencer, observing its
// pins only. It is attached to every instance of the top by the bind below.
module sdram_init_chk #(
    parameter int T_MRD     = 2,
    parameter int N_REFRESH = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [1:0]  ba,
    input logic [12:0] addr,
    input logic        init_done
);

    localparam int RW = $clog2(N_REFRESH + 2);
    localparam int MW = $clog2(T_MRD + 2);

    logic [3:0]    cmd;
    logic [RW-1:0] refs_seen;
    logic [MW-1:0] since_lmr;
    logic          pre_seen;
    logic          lmr_seen;

    // Gather the strobes into one command level
    always_comb begin
        cmd = {cs_n, ras_n, cas_n, we_n};
    end

    // Track script progress from the pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refs_seen <= '0;
            since_lmr <= '0;
            pre_seen  <= 1'b0;
            lmr_seen  <= 1'b0;
        end else begin
            if (cmd == 4'b0010) pre_seen <= 1'b1;
            if (cmd == 4'b0000) lmr_seen <= 1'b1;
            if (cmd == 4'b0001 && refs_seen != RW'(N_REFRESH + 1)) refs_seen <= refs_seen + 1'b1;
            if (cmd == 4'b0000) begin
                since_lmr <= MW'(1);
            end else if (since_lmr != '0 && since_lmr != MW'(T_MRD + 1)) begin
                since_lmr <= since_lmr + 1'b1;
            end
        end
    end

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r7_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> cmd == 4'b0111);

    a_r7_done_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> since_lmr == MW'(T_MRD));

    a_r3_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0010 |-> (addr == 13'h0400 && ba == 2'b00));

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0000 |-> (addr[2] == 1'b0 && addr[8:7] == 2'b00 && addr[12:10] == 3'b000 && ba == 2'b00));

    a_r2_refresh_tally: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0000 |-> refs_seen == RW'(N_REFRESH));

    a_r2_idle_after_lmr: assert property (@(posedge clk) disable iff (!rst_n)
        lmr_seen |-> cmd == 4'b0111);

    a_r1_pre_first: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_seen |-> (cmd == 4'b0111 || cmd == 4'b0010));

endmodule

bind sdram_init_seq sdram_init_chk #(
    .T_MRD     (T_MRD),
    .N_REFRESH (N_REFRESH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
// Bench: timeline reference model compared against two sequencer instances
// on every clock: u0 with default timing, u1 with unit gaps and one refresh.
module sim_sdram_init_seq;

    localparam int P0 = 12500, RP0 = 3, RFC0 = 8, MRD0 = 2, NR0 = 2;
    localparam int P1 = 3,     RP1 = 1, RFC1 = 1, MRD1 = 1, NR1 = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bl = 2'd0;
    logic        bt = 1'b0;
    logic [2:0]  cas = 3'd0;
    logic        wrs = 1'b0;
    logic        cs0, ras0, cas0, we0, done0;
    logic        cs1, ras1, cas1, we1, done1;
    logic [1:0]  ba0, ba1;
    logic [12:0] a0, a1;

    int n_chk = 0;
    int n_bad = 0;
    int n_edge = 0;
    int run_bl = 0;
    bit mid_reset = 1'b0;
    bit finished = 1'b0;
    int c_pre = 0, c_ref = 0, c_lmr = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    sdram_init_seq u0 (
        .clk(clk), .rst_n(rst_n), .mode_bl_code(bl), .mode_bt(bt),
        .mode_cas(cas), .mode_wr_single(wrs),
        .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0),
        .ba(ba0), .addr(a0), .init_done(done0)
    );

    sdram_init_seq #(
        .T_POWERUP(P1), .T_RP(RP1), .T_RFC(RFC1), .T_MRD(MRD1), .N_REFRESH(NR1)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .mode_bl_code(bl), .mode_bt(bt),
        .mode_cas(cas), .mode_wr_single(wrs),
        .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1),
        .ba(ba1), .addr(a1), .init_done(done1)
    );

    // Reference: which command belongs in cycle n of the timeline
    function automatic int exp_cmd(int n, int p, int rp, int rfc, int nr);
        int first_ref = p + rp;
        if (n == p) return 2;
        for (int k = 0; k < nr; k++) if (n == first_ref + k * rfc) return 1;
        if (n == first_ref + nr * rfc) return 0;
        return 7;
    endfunction

    function automatic int exp_done(int n, int p, int rp, int rfc, int mrd, int nr);
        return (n >= p + rp + nr * rfc + mrd) ? 1 : 0;
    endfunction

    function automatic int exp_addr(int c);
        if (c == 2) return 1024;
        if (c == 0) return int'(bl) + 8 * int'(bt) + 16 * int'(cas) + 512 * int'(wrs);
        return 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at edge %0d", req, what, act, exp, n_edge);
        end
    endtask

    // Reference cycle counter: edges seen with reset released
    always @(posedge clk) begin
        if (!rst_n) n_edge <= 0;
        else n_edge <= n_edge + 1;
    end

    // Compare both instances to the model, then move the mode inputs
    always @(negedge clk) begin
        int e0, e1, d0, d1;
        string t0;
        e0 = exp_cmd(n_edge, P0, RP0, RFC0, NR0);
        d0 = exp_done(n_edge, P0, RP0, RFC0, MRD0, NR0);
        if (!rst_n || n_edge < P0) t0 = mid_reset ? "R8" : "R1";
        else if (e0 == 2) t0 = "R3";
        else if (e0 == 1) t0 = "R4";
        else if (e0 == 0) t0 = "R5";
        else if (d0 == 1) t0 = "R7";
        else t0 = "R2";
        chk(t0, "u0 cmd", int'({cs0, ras0, cas0, we0}), e0);
        chk(t0, "u0 addr", int'(a0), exp_addr(e0));
        chk(t0, "u0 ba", int'(ba0), 0);
        chk((d0 == 1) ? "R7" : t0, "u0 init_done", int'(done0), d0);
        if (e0 == 0) begin
            chk("R6", "u0 burst field", int'(a0[2:0]), int'(bl));
            chk("R6", "u0 burst code of run", int'(bl), run_bl);
        end
        if ({cs0, ras0, cas0, we0} == 4'b0010) c_pre++;
        if ({cs0, ras0, cas0, we0} == 4'b0001) c_ref++;
        if ({cs0, ras0, cas0, we0} == 4'b0000) c_lmr++;

        e1 = exp_cmd(n_edge, P1, RP1, RFC1, NR1);
        d1 = exp_done(n_edge, P1, RP1, RFC1, MRD1, NR1);
        chk("R9", "u1 cmd", int'({cs1, ras1, cas1, we1}), e1);
        chk("R9", "u1 addr", int'(a1), exp_addr(e1));
        chk("R9", "u1 ba", int'(ba1), 0);
        chk("R9", "u1 init_done", int'(done1), d1);

        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bt   = lfsr[0];
        cas  = lfsr[3:1];
        wrs  = lfsr[4];
    end

    // Runs: four full sequences, one cut short by reset
    initial begin
        repeat (4) @(negedge clk);
        for (int r = 0; r < 5; r++) begin
            run_bl = (r < 4) ? r : 3;
            bl = 2'(run_bl);
            @(posedge clk);
            c_pre = 0; c_ref = 0; c_lmr = 0;
            @(negedge clk);
            rst_n = 1'b1;
            if (r == 2) begin
                repeat (P0 / 2) @(negedge clk);
                mid_reset = 1'b1;
            end else begin
                repeat (P0 + RP0 + NR0 * RFC0 + MRD0 + 40) @(negedge clk);
                @(posedge clk);
                chk("R2", "precharge count", c_pre, 1);
                chk("R2", "refresh count", c_ref, NR0);
                chk("R2", "load-mode count", c_lmr, 1);
                @(negedge clk);
            end
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule